// File: doc/BRIEF.md
# Regulator Start-Up Sequencer with Power-Good Qualification

This block runs the digital side of a buck regulator's start-up. Once the regulator is allowed to run, it waits a fixed settling interval. It then raises a reference code one step at a time from zero to full scale, where full scale stands for the 0.6 V regulation target. When the code reaches full scale, the sequencer reports soft start as finished and holds the reference at the fixed full-scale value. Power good is released only after the feedback voltage has stayed inside its window for a qualification interval.

A timing select doubles as a stretch control. With it set, both the interval per ramp step and the power-good delay are multiplied by a parameter (four by default). The select is read once, at the start of each sequence. The window comparators lie outside the block. Their two flags ("above the low limit", "below the high limit") are combined here. Power good is released slowly after a long run of in-window cycles and pulled down quickly after a short run of out-of-window cycles. Dropping enable, losing supply validity or asking for a restart returns everything to idle at once.

Top module: `sseq_top`

## Requirements
- R1: Out of reset, and whenever idle, `refCode` is 0, `ssDone` is 0 and `pgPullDown` is 1.
- R2: When the run condition (enable high, supplyOk high, restartReq low) is first sampled at clock edge E, `refCode` stays 0 through edge E+DLY_CYC+STEP-1, where STEP is the active step interval.
- R3: During the ramp `refCode` rises by exactly one every STEP cycles, reaching 1 after edge E+DLY_CYC+STEP. STEP is STEP_CYC with `sel4x`=0 and STEP_CYC*SCALE with `sel4x`=1. The code never skips a value and never decreases except to 0.
- R4: `ssDone` rises in the same cycle that `refCode` reaches full scale (2^REF_BITS-1), at edge E+DLY_CYC+(2^REF_BITS-1)*STEP. From then on `refCode` holds at full scale.
- R5: After soft start ends, `pgPullDown` falls after PG consecutive in-window cycles. PG is PG_CYC, or PG_CYC*SCALE with `sel4x`=1. The pin is never released before `ssDone`.
- R6: While power good is released, `pgPullDown` rises on the edge that samples the DROP_CYC-th consecutive out-of-window cycle. An excursion shorter than that leaves it low.
- R7: After a drop, power good is released again only after PG new consecutive in-window cycles.
- R8: If enable is low, supplyOk is low or restartReq is high at an edge, the block is idle after that edge (R1 outputs).
- R9: `sel4x` is captured when a sequence starts. Changing it later has no effect on that sequence's timing.
- R10: Feedback counts as in-window only when `fbAboveLow` and `fbBelowHigh` are both 1. Either flag at 0 counts as out of window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Regulator run request |
| supplyOk | input | 1 | Input supply high enough for valid logic |
| restartReq | input | 1 | Restart after a fault, forces idle |
| fbAboveLow | input | 1 | Feedback above the low window limit |
| fbBelowHigh | input | 1 | Feedback below the high window limit |
| sel4x | input | 1 | Stretch ramp and power-good delay by SCALE |
| refCode | output | REF_BITS | Reference code for the DAC |
| ssDone | output | 1 | Soft start finished, fixed reference in use |
| pgPullDown | output | 1 | Drive for the open-drain power-good pin (1 = pull low) |

## Verification
The main sequence runs three times: once unstretched, once stretched, and once unstretched with the select toggled mid-ramp. Comparing the first two shows that the stretch scales the step interval and the power-good delay by the same factor. The third shows that the select is captured at start. At the first step, the second step, the last step and the power-good edge, the samples are taken one cycle apart, so an off-by-one in any counter is caught. Window excursions use each flag on its own, one cycle short of the drop length and then at the full length, which separates the fast drop path from the slow re-qualification. Restart and supply loss are applied mid-ramp and in the running state to prove an immediate return to idle.

// File: rtl/sseq_pkg.sv
package sseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DELAY,
    ST_RAMP,
    ST_PGWAIT,
    ST_RUN
  } seqState_t;

  // Strobes from the control FSM to the timing datapath
  typedef struct packed {
    logic kill;      // clear everything, back to idle values
    logic arm;       // a new sequence starts: capture timing select
    logic tmrZero;   // state change: restart the shared interval timer
    logic delayRun;  // start delay is counting
    logic rampRun;   // soft-start ramp is stepping
    logic pgRun;     // power-good qualification is counting
    logic watchRun;  // power good released, watching for drop
  } seqStrobe_t;

endpackage

// File: rtl/sseq_datapath.sv
module sseq_datapath
  import sseq_pkg::*;
#(
  parameter int REF_BITS = 10,
  parameter int DLY_CYC  = 10000,
  parameter int STEP_CYC = 20,
  parameter int PG_CYC   = 15000,
  parameter int DROP_CYC = 500,
  parameter int SCALE    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          strobe,
  input  logic                inWin,
  input  logic                sel4x,
  input  logic                useFixed,
  output logic [REF_BITS-1:0] refCode,
  output logic                delayDone,
  output logic                lastStep,
  output logic                pgDone,
  output logic                dropNow
);

  localparam int SCALED_STEP = STEP_CYC * SCALE;
  localparam int SCALED_PG   = PG_CYC * SCALE;
  localparam int MAX_A       = (DLY_CYC > SCALED_STEP) ? DLY_CYC : SCALED_STEP;
  localparam int MAX_C       = (MAX_A > SCALED_PG) ? MAX_A : SCALED_PG;
  localparam int TMR_W       = $clog2(MAX_C + 1);
  localparam int DROP_W      = $clog2(DROP_CYC + 1);

  localparam logic [REF_BITS-1:0] FULL_CODE = {REF_BITS{1'b1}};
  localparam logic [TMR_W-1:0]    DLY_LAST  = TMR_W'(DLY_CYC - 1);
  localparam logic [TMR_W-1:0]    STEP_1X   = TMR_W'(STEP_CYC - 1);
  localparam logic [TMR_W-1:0]    STEP_NX   = TMR_W'(SCALED_STEP - 1);
  localparam logic [TMR_W-1:0]    PG_1X     = TMR_W'(PG_CYC - 1);
  localparam logic [TMR_W-1:0]    PG_NX     = TMR_W'(SCALED_PG - 1);
  localparam logic [DROP_W-1:0]   DROP_LAST = DROP_W'(DROP_CYC - 1);

  logic                scaleLat;
  logic [TMR_W-1:0]    tmr;
  logic [DROP_W-1:0]   drp;
  logic [REF_BITS-1:0] rampCode;
  logic [TMR_W-1:0]    stepLimit;
  logic [TMR_W-1:0]    pgLimit;
  logic                stepTick;

  assign stepLimit = scaleLat ? STEP_NX : STEP_1X;
  assign pgLimit   = scaleLat ? PG_NX : PG_1X;

  // Timing select is captured once per sequence
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           scaleLat <= 1'b0;
    else if (strobe.kill) scaleLat <= 1'b0;
    else if (strobe.arm)  scaleLat <= sel4x;
  end

  // Shared interval timer: start delay, step prescaler, power-good delay
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                       tmr <= '0;
    else if (strobe.kill || strobe.arm || strobe.tmrZero) tmr <= '0;
    else if (strobe.delayRun)                        tmr <= tmr + 1'b1;
    else if (strobe.rampRun)                         tmr <= stepTick ? '0 : tmr + 1'b1;
    else if (strobe.pgRun)                           tmr <= inWin ? tmr + 1'b1 : '0;
    else                                             tmr <= '0;
  end

  assign delayDone = strobe.delayRun && (tmr == DLY_LAST);
  assign stepTick  = strobe.rampRun && (tmr == stepLimit);
  assign lastStep  = stepTick && (rampCode == FULL_CODE - 1'b1);
  assign pgDone    = strobe.pgRun && inWin && (tmr == pgLimit);

  // Soft-start ramp code
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rampCode <= '0;
    else if (strobe.kill) rampCode <= '0;
    else if (stepTick)    rampCode <= rampCode + 1'b1;
  end

  // Out-of-window run length while power good is released
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                           drp <= '0;
    else if (!strobe.watchRun || inWin || strobe.tmrZero) drp <= '0;
    else                                                 drp <= drp + 1'b1;
  end

  assign dropNow = strobe.watchRun && !inWin && (drp == DROP_LAST);

  // Fixed reference once soft start is over
  assign refCode = useFixed ? FULL_CODE : rampCode;

  // R3: ramp moves by one or returns to zero
  p_ref_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rampCode != $past(rampCode)) |-> (rampCode == $past(rampCode) + 1'b1 || rampCode == '0))
    else $error("ramp code jumped");

  // R4: the fixed reference is only selected once the ramp has finished
  p_ramp_full_r4: assert property (@(posedge clk) disable iff (!rstN)
    useFixed |-> (rampCode == FULL_CODE))
    else $error("fixed reference before ramp end");

  // R9: captured select stays put during the ramp
  p_scale_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rampRun && $past(strobe.rampRun)) |-> $stable(scaleLat))
    else $error("timing select moved mid-ramp");

endmodule

// File: rtl/sseq_ctrl.sv
module sseq_ctrl
  import sseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       supplyOk,
  input  logic       restartReq,
  input  logic       inWin,
  input  logic       delayDone,
  input  logic       lastStep,
  input  logic       pgDone,
  input  logic       dropNow,
  output seqStrobe_t strobe,
  output logic       ssDone,
  output logic       pgPullDown
);

  seqState_t state;
  seqState_t nextState;
  logic      active;

  assign active = enable && supplyOk && !restartReq;

  always_comb begin
    nextState = state;
    if (!active) begin
      nextState = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:   nextState = ST_DELAY;
        ST_DELAY:  if (delayDone) nextState = ST_RAMP;
        ST_RAMP:   if (lastStep)  nextState = ST_PGWAIT;
        ST_PGWAIT: if (pgDone)    nextState = ST_RUN;
        ST_RUN:    if (dropNow)   nextState = ST_PGWAIT;
        default:   nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strobe          = '0;
    strobe.kill     = !active;
    strobe.arm      = active && (state == ST_IDLE);
    strobe.tmrZero  = active && (nextState != state);
    strobe.delayRun = (state == ST_DELAY);
    strobe.rampRun  = (state == ST_RAMP);
    strobe.pgRun    = (state == ST_PGWAIT);
    strobe.watchRun = (state == ST_RUN);
  end

  assign ssDone     = (state == ST_PGWAIT) || (state == ST_RUN);
  assign pgPullDown = (state != ST_RUN);

  // R8: loss of the run condition lands in idle on the next edge
  p_kill_r8: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> (state == ST_IDLE))
    else $error("not idle after run condition dropped");

  // R5: release only follows qualification
  p_run_entry_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> ($past(state) == ST_RUN || $past(state) == ST_PGWAIT))
    else $error("power good released without qualification");

  // R6: in-window cycles never drop power good
  p_hold_run_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && inWin && active) |=> (state == ST_RUN))
    else $error("power good dropped while in window");

endmodule

// File: rtl/sseq_top.sv
module sseq_top
  import sseq_pkg::*;
#(
  parameter int REF_BITS = 10,
  parameter int DLY_CYC  = 10000,
  parameter int STEP_CYC = 20,
  parameter int PG_CYC   = 15000,
  parameter int DROP_CYC = 500,
  parameter int SCALE    = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                supplyOk,
  input  logic                restartReq,
  input  logic                fbAboveLow,
  input  logic                fbBelowHigh,
  input  logic                sel4x,
  output logic [REF_BITS-1:0] refCode,
  output logic                ssDone,
  output logic                pgPullDown
);

  seqStrobe_t strobe;
  logic inWin;
  logic delayDone;
  logic lastStep;
  logic pgDone;
  logic dropNow;

  assign inWin = fbAboveLow && fbBelowHigh;

  sseq_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .supplyOk   (supplyOk),
    .restartReq (restartReq),
    .inWin      (inWin),
    .delayDone  (delayDone),
    .lastStep   (lastStep),
    .pgDone     (pgDone),
    .dropNow    (dropNow),
    .strobe     (strobe),
    .ssDone     (ssDone),
    .pgPullDown (pgPullDown)
  );

  sseq_datapath #(
    .REF_BITS (REF_BITS),
    .DLY_CYC  (DLY_CYC),
    .STEP_CYC (STEP_CYC),
    .PG_CYC   (PG_CYC),
    .DROP_CYC (DROP_CYC),
    .SCALE    (SCALE)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inWin     (inWin),
    .sel4x     (sel4x),
    .useFixed  (ssDone),
    .refCode   (refCode),
    .delayDone (delayDone),
    .lastStep  (lastStep),
    .pgDone    (pgDone),
    .dropNow   (dropNow)
  );

endmodule

// File: tb/sseq_top_test.sv
module sseq_top_test;

  localparam int REF_BITS = 6;
  localparam int DLY      = 20;
  localparam int STEP     = 2;
  localparam int PG       = 30;
  localparam int DROP     = 5;
  localparam int SCALE    = 4;
  localparam int FULL     = (1 << REF_BITS) - 1;
  localparam int NROW     = 3;

  // Vector table: timing select, flip select mid-ramp, expected step, expected pg delay
  localparam int  V_SEL  [NROW] = '{0, 1, 0};
  localparam int  V_FLIP [NROW] = '{0, 0, 1};
  localparam int  V_STEP [NROW] = '{STEP, STEP*SCALE, STEP};
  localparam int  V_PG   [NROW] = '{PG, PG*SCALE, PG};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic supplyOk = 1'b1;
  logic restartReq = 1'b0;
  logic fbAboveLow = 1'b1;
  logic fbBelowHigh = 1'b1;
  logic sel4x = 1'b0;
  logic [REF_BITS-1:0] refCode;
  logic ssDone;
  logic pgPullDown;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sseq_top #(
    .REF_BITS (REF_BITS),
    .DLY_CYC  (DLY),
    .STEP_CYC (STEP),
    .PG_CYC   (PG),
    .DROP_CYC (DROP),
    .SCALE    (SCALE)
  ) uut (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .supplyOk    (supplyOk),
    .restartReq  (restartReq),
    .fbAboveLow  (fbAboveLow),
    .fbBelowHigh (fbBelowHigh),
    .sel4x       (sel4x),
    .refCode     (refCode),
    .ssDone      (ssDone),
    .pgPullDown  (pgPullDown)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic waitTo(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic chkIdle(input string req);
    chk(req, int'(refCode), 0);
    chk(req, int'(ssDone), 0);
    chk(req, int'(pgPullDown), 1);
  endtask

  initial begin
    int e0;
    int c;
    repeat (3) @(negedge clk);
    chkIdle("R1 reset");
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NROW; i++) begin
      enable = 1'b0;
      repeat (2) @(negedge clk);
      chkIdle("R8 disabled idle");
      sel4x = V_SEL[i][0];
      enable = 1'b1;
      e0 = cyc + 1;
      waitTo(e0 + DLY + V_STEP[i] - 1);
      chk("R2 still zero before first step", int'(refCode), 0);
      waitTo(e0 + DLY + V_STEP[i]);
      chk("R3 first step", int'(refCode), 1);
      if (V_FLIP[i] != 0) sel4x = ~sel4x;
      waitTo(e0 + DLY + 2*V_STEP[i]);
      chk("R3 second step", int'(refCode), 2);
      waitTo(e0 + DLY + FULL*V_STEP[i] - 1);
      chk("R4 last step pending code", int'(refCode), FULL - 1);
      chk("R4 not yet done", int'(ssDone), 0);
      waitTo(e0 + DLY + FULL*V_STEP[i]);
      chk("R4 done flag", int'(ssDone), 1);
      chk("R4 fixed reference", int'(refCode), FULL);
      waitTo(e0 + DLY + FULL*V_STEP[i] + V_PG[i] - 1);
      chk("R5 pg held low", int'(pgPullDown), 1);
      if (V_FLIP[i] != 0) chk("R9 late select ignored", int'(pgPullDown), 1);
      waitTo(e0 + DLY + FULL*V_STEP[i] + V_PG[i]);
      chk("R5 pg released", int'(pgPullDown), 0);
    end
    sel4x = 1'b0;

    // R6/R10: short excursion on the high flag is filtered
    c = cyc;
    fbBelowHigh = 1'b0;
    waitTo(c + DROP - 1);
    fbBelowHigh = 1'b1;
    waitTo(c + DROP + 2);
    chk("R6 R10 short excursion ignored", int'(pgPullDown), 0);

    // R6/R10: full-length excursion on the low flag drops power good
    c = cyc;
    fbAboveLow = 1'b0;
    waitTo(c + DROP - 1);
    chk("R6 one cycle before drop", int'(pgPullDown), 0);
    waitTo(c + DROP);
    chk("R6 R10 dropped", int'(pgPullDown), 1);
    chk("R6 ss stays done", int'(ssDone), 1);

    // R7: full re-qualification
    fbAboveLow = 1'b1;
    c = cyc;
    waitTo(c + PG - 1);
    chk("R7 still low", int'(pgPullDown), 1);
    waitTo(c + PG);
    chk("R7 re-released", int'(pgPullDown), 0);

    // R8: restart request in run state
    c = cyc;
    restartReq = 1'b1;
    waitTo(c + 1);
    chkIdle("R8 restart");
    restartReq = 1'b0;
    e0 = cyc + 1;
    waitTo(e0 + DLY + 10*STEP);
    chk("R3 ramp after restart", int'(refCode), 10);

    // R8: supply loss mid-ramp
    c = cyc;
    supplyOk = 1'b0;
    waitTo(c + 1);
    chkIdle("R8 supply loss");
    enable = 1'b0;
    supplyOk = 1'b1;
    waitTo(c + DLY + 5);
    chkIdle("R8 enable low stays idle");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cyc >= 20000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule